// File: doc/BRIEF.md
# E3 Frame Overhead Alarm Monitor

This block watches the overhead octets of a received E3 frame in the G.832 structure. Each frame, an upstream aligner presents the two framing octets, the error-monitor octet, the trail-trace octet, the maintenance/adaptation octet, the network-operator octet and the general-purpose communication octet in parallel. It also presents the BIP-8 value computed locally over the previous frame, and pulses a single-cycle frame strobe. From these inputs the block raises per-frame alarm events. Each event sets a sticky bit in a status register that clears when read. An interrupt line is asserted when any set status bit is also enabled.

The far-end receive failure indication is debounced. The alarm state is declared only after a run of 3 consecutive frames (or 5, chosen by configuration) that carry the indication. It is withdrawn only after an equal run of consecutive frames that do not carry it. Both transitions raise an interrupt. A payload-type change is detected by comparing the current frame's payload-type field with the previous frame's value. A control register steers either the network-operator octet or the general-purpose octet onward as the data-link byte for a downstream LAPD receiver.

Top module: `e3_ovhd_monitor`

## Requirements
- R1: After reset, the status register (0x14), interrupt-enable register (0x15), configuration register (0x16) and data-link control register (0x18) all read 0, and irqOut and ferfState are 0.
- R2: A frame whose trail-trace octet has bit 7 set sets status bit 5.
- R3: A frame whose maintenance octet has bit 6 (FEBE) set sets status bit 4.
- R4: A frame whose error-monitor octet differs from bipIn sets status bit 2.
- R5: A frame with fa1In other than 0xF6, or fa2In other than 0x28, sets status bit 1.
- R6: A frame whose maintenance bits [5:3] (payload type) differ from those of the previous frame sets status bit 0. The first frame after reset is not compared.
- R7: ferfState becomes 1 after N consecutive frames with maintenance bit 7 set, and becomes 0 after N consecutive frames with that bit clear. A frame that matches the current state restarts the count. N is 3 when bit 0 of register 0x16 is 0, and 5 when it is 1. ferfState changes at the clock edge of the Nth strobe.
- R8: Each change of ferfState, in either direction, sets status bit 3. No other frame sets it.
- R9: Reading 0x14 returns the status bits, and the read clears them. A status bit that is set and not read stays set. When an event and a status read fall in the same cycle, the read returns the old value and the event's bit remains set.
- R10: irqOut is 1 exactly when a status bit and the matching bit of register 0x15 are both 1.
- R11: Register 0x18 stores bits 3..1 and reads all other bits as 0. Bit 3 = 1 selects nrIn as dlByte, and 0 selects gcIn. Bit 2 gates dlValid, which equals frameStb while bit 2 is set. Bit 1 is a stored interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | One-cycle strobe marking valid overhead inputs |
| fa1In | input | 8 | First framing octet |
| fa2In | input | 8 | Second framing octet |
| emIn | input | 8 | Received error-monitor octet |
| bipIn | input | 8 | Locally computed BIP-8 of the previous frame |
| trIn | input | 8 | Trail-trace octet |
| maIn | input | 8 | Maintenance/adaptation octet |
| nrIn | input | 8 | Network-operator octet |
| gcIn | input | 8 | General-purpose communication octet |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from address |
| irqOut | output | 1 | Interrupt request |
| ferfState | output | 1 | Debounced far-end receive failure state |
| dlByte | output | 8 | Selected data-link octet |
| dlValid | output | 1 | Data-link octet valid |

## Verification
The status bits and ferfState are registered on the clock edge that samples frameStb, so they are due one cycle after the strobe. The bench therefore drives each frame on a falling edge and reads status only after the following falling edge. Read data and dlByte/dlValid are combinational and are sampled 1 ns after the inputs are driven, within the same cycle. The read-clear takes effect at the next rising edge. Because irqOut is derived from registers, it is checked on the falling edge after the frame or read that changed the status.

// File: rtl/e3_ovhd_pkg.sv
package e3_ovhd_pkg;
  localparam logic [7:0] ADDR_STAT = 8'h14;
  localparam logic [7:0] ADDR_IEN  = 8'h15;
  localparam logic [7:0] ADDR_CFG  = 8'h16;
  localparam logic [7:0] ADDR_LAPD = 8'h18;
  localparam logic [7:0] FA1_EXP   = 8'hF6;
  localparam logic [7:0] FA2_EXP   = 8'h28;
  localparam int NUM_EV = 6;

  // packed order matches status bit positions: trail=5 ... ptMis=0
  typedef struct packed {
    logic trail;
    logic febe;
    logic ferf;
    logic bip;
    logic framing;
    logic ptMis;
  } evStrobe_t;

  typedef struct packed {
    logic ferfWin5;
    logic dlFromNr;
    logic lapdEn;
  } cfg_t;
endpackage

// File: rtl/e3_ovhd_datapath.sv
module e3_ovhd_datapath
  import e3_ovhd_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FERF_SHORT = 3,
  parameter int FERF_LONG  = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStb,
  input  logic [DW-1:0] fa1In,
  input  logic [DW-1:0] fa2In,
  input  logic [DW-1:0] emIn,
  input  logic [DW-1:0] bipIn,
  input  logic [DW-1:0] trIn,
  input  logic [DW-1:0] maIn,
  input  logic [DW-1:0] nrIn,
  input  logic [DW-1:0] gcIn,
  input  cfg_t          cfg,
  output evStrobe_t     evOut,
  output logic          ferfState,
  output logic [DW-1:0] dlByte,
  output logic          dlValid
);
  localparam int CW  = $clog2(FERF_LONG + 1);
  localparam int PTW = 3;

  logic          ferfBit, febeBit;
  logic [PTW-1:0] ptNow, ptPrev;
  logic          ptSeen;
  logic          ferfQ, ferfFlip;
  logic [CW-1:0] runCnt, runLimit;
  logic [CW:0]   runNext;

  assign ferfBit  = maIn[DW-1];
  assign febeBit  = maIn[DW-2];
  assign ptNow    = maIn[DW-3 -: PTW];
  assign runLimit = cfg.ferfWin5 ? CW'(FERF_LONG) : CW'(FERF_SHORT);
  assign runNext  = {1'b0, runCnt} + 1'b1;
  assign ferfFlip = frameStb && (ferfBit != ferfQ) && (runNext >= {1'b0, runLimit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ferfQ  <= 1'b0;
      runCnt <= '0;
    end else if (frameStb) begin
      if (ferfBit == ferfQ) begin
        runCnt <= '0;
      end else if (ferfFlip) begin
        ferfQ  <= ~ferfQ;
        runCnt <= '0;
      end else begin
        runCnt <= runNext[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptPrev <= '0;
      ptSeen <= 1'b0;
    end else if (frameStb) begin
      ptPrev <= ptNow;
      ptSeen <= 1'b1;
    end
  end

  always_comb begin
    evOut.trail   = frameStb && trIn[DW-1];
    evOut.febe    = frameStb && febeBit;
    evOut.ferf    = ferfFlip;
    evOut.bip     = frameStb && (emIn != bipIn);
    evOut.framing = frameStb && ((fa1In != FA1_EXP) || (fa2In != FA2_EXP));
    evOut.ptMis   = frameStb && ptSeen && (ptNow != ptPrev);
  end

  assign ferfState = ferfQ;
  assign dlByte    = cfg.dlFromNr ? nrIn : gcIn;
  assign dlValid   = frameStb && cfg.lapdEn;
endmodule

// File: rtl/e3_ovhd_ctrl.sv
module e3_ovhd_ctrl
  import e3_ovhd_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  evStrobe_t         ev,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [AW-1:0]     regAddr,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  output cfg_t              cfg,
  output logic [NUM_EV-1:0] statusQ,
  output logic              irqOut
);
  logic [NUM_EV-1:0] ienQ;
  logic              winQ;
  logic [2:0]        lapdQ;
  logic              hitStat, hitIen, hitCfg, hitLapd;

  assign hitStat = regAddr == AW'(ADDR_STAT);
  assign hitIen  = regAddr == AW'(ADDR_IEN);
  assign hitCfg  = regAddr == AW'(ADDR_CFG);
  assign hitLapd = regAddr == AW'(ADDR_LAPD);

  // event is OR-ed after the clear so a same-cycle event survives the read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= ((regRdEn && hitStat) ? '0 : statusQ) | NUM_EV'(ev);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienQ  <= '0;
      winQ  <= 1'b0;
      lapdQ <= '0;
    end else if (regWrEn) begin
      if (hitIen)  ienQ  <= regWrData[NUM_EV-1:0];
      if (hitCfg)  winQ  <= regWrData[0];
      if (hitLapd) lapdQ <= regWrData[3:1];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      if (hitStat)      regRdData[NUM_EV-1:0] = statusQ;
      else if (hitIen)  regRdData[NUM_EV-1:0] = ienQ;
      else if (hitCfg)  regRdData[0]          = winQ;
      else if (hitLapd) regRdData[3:1]        = lapdQ;
    end
  end

  assign cfg.ferfWin5 = winQ;
  assign cfg.dlFromNr = lapdQ[2];
  assign cfg.lapdEn   = lapdQ[1];
  assign irqOut       = |(statusQ & ienQ);
endmodule

// File: rtl/e3_ovhd_monitor.sv
module e3_ovhd_monitor
  import e3_ovhd_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int FERF_SHORT = 3,
  parameter int FERF_LONG  = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStb,
  input  logic [DW-1:0] fa1In,
  input  logic [DW-1:0] fa2In,
  input  logic [DW-1:0] emIn,
  input  logic [DW-1:0] bipIn,
  input  logic [DW-1:0] trIn,
  input  logic [DW-1:0] maIn,
  input  logic [DW-1:0] nrIn,
  input  logic [DW-1:0] gcIn,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output logic          irqOut,
  output logic          ferfState,
  output logic [DW-1:0] dlByte,
  output logic          dlValid
);
  evStrobe_t         evBus;
  cfg_t              cfgBus;
  logic [NUM_EV-1:0] statusQ;

  e3_ovhd_datapath #(.DW(DW), .FERF_SHORT(FERF_SHORT), .FERF_LONG(FERF_LONG)) dp (
    .clk(clk), .rstN(rstN), .frameStb(frameStb),
    .fa1In(fa1In), .fa2In(fa2In), .emIn(emIn), .bipIn(bipIn),
    .trIn(trIn), .maIn(maIn), .nrIn(nrIn), .gcIn(gcIn),
    .cfg(cfgBus), .evOut(evBus), .ferfState(ferfState),
    .dlByte(dlByte), .dlValid(dlValid)
  );

  e3_ovhd_ctrl #(.DW(DW), .AW(AW)) ctl (
    .clk(clk), .rstN(rstN), .ev(evBus),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .cfg(cfgBus), .statusQ(statusQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/e3_ovhd_checker.sv
module e3_ovhd_checker
  import e3_ovhd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStb,
  input logic              trMsb,
  input logic              febeBit,
  input logic              regRdEn,
  input logic [AW-1:0]     regAddr,
  input logic [NUM_EV-1:0] statusQ,
  input logic              ferfState
);
  logic rdStat;
  assign rdStat = regRdEn && (regAddr == AW'(ADDR_STAT));

  assert_trail_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameStb && trMsb |=> statusQ[5]);

  assert_febe_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameStb && febeBit |=> statusQ[4]);

  assert_ferf_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> $stable(ferfState));

  assert_ferf_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ferfState) |-> statusQ[3]);

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdStat && !frameStb |=> statusQ == '0);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStat |=> (statusQ & $past(statusQ)) == $past(statusQ));
endmodule

bind e3_ovhd_monitor e3_ovhd_checker #(.AW(AW)) chk (
  .clk(clk), .rstN(rstN), .frameStb(frameStb),
  .trMsb(trIn[DW-1]), .febeBit(maIn[DW-2]),
  .regRdEn(regRdEn), .regAddr(regAddr),
  .statusQ(statusQ), .ferfState(ferfState)
);

// File: tb/e3_ovhd_monitor_test.sv
module e3_ovhd_monitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 1'b0;
  logic [7:0] fa1In = 8'hF6, fa2In = 8'h28, emIn = 8'h00, bipIn = 8'h00;
  logic [7:0] trIn = 8'h00, maIn = 8'h00, nrIn = 8'h00, gcIn = 8'h00;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00;
  logic [7:0] regRdData, dlByte;
  logic irqOut, ferfState, dlValid;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  e3_ovhd_monitor uut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb),
    .fa1In(fa1In), .fa2In(fa2In), .emIn(emIn), .bipIn(bipIn),
    .trIn(trIn), .maIn(maIn), .nrIn(nrIn), .gcIn(gcIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .ferfState(ferfState), .dlByte(dlByte), .dlValid(dlValid)
  );

  // fields: fa1, fa2, em, bip, tr, ma, expected status
  localparam logic [55:0] VECS [0:8] = '{
    56'hF6_28_11_11_00_08_00,
    56'hF6_28_11_11_80_08_20,
    56'hF6_28_11_11_00_48_10,
    56'hF6_28_12_11_00_08_04,
    56'hF7_28_11_11_00_08_02,
    56'hF6_29_11_11_00_08_02,
    56'hF6_28_11_11_00_10_01,
    56'hF6_28_11_11_00_10_00,
    56'h00_28_00_01_FF_58_37
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start just after a falling edge and return just after one
  task automatic sendFrame(input logic [7:0] f1, f2, em, bip, tr, ma);
    fa1In = f1; fa2In = f2; emIn = em; bipIn = bip; trIn = tr; maIn = ma;
    frameStb = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
  endtask

  task automatic goodFrame(input logic [7:0] tr, ma);
    sendFrame(8'hF6, 8'h28, 8'h5C, 8'h5C, tr, ma);
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(8'h14, rd); chk("R1 status", rd, 8'h00);
    readReg(8'h15, rd); chk("R1 ienable", rd, 8'h00);
    readReg(8'h16, rd); chk("R1 config", rd, 8'h00);
    readReg(8'h18, rd); chk("R1 lapd ctrl", rd, 8'h00);
    chk("R1 irq/ferf", {6'd0, irqOut, ferfState}, 8'h00);

    // vector table: R2 R3 R4 R5 R6 event bits
    for (int i = 0; i < 9; i++) begin
      sendFrame(VECS[i][55:48], VECS[i][47:40], VECS[i][39:32],
                VECS[i][31:24], VECS[i][23:16], VECS[i][15:8]);
      readReg(8'h14, rd);
      chk($sformatf("R2-R6 vector %0d", i), rd, VECS[i][7:0]);
    end

    // R7 R8 debounce with N=3
    goodFrame(8'h00, 8'h98); goodFrame(8'h00, 8'h98);
    chk("R7 n3 not yet", {7'd0, ferfState}, 8'h00);
    readReg(8'h14, rd); chk("R8 no event early", rd, 8'h00);
    goodFrame(8'h00, 8'h98);
    chk("R7 n3 declared", {7'd0, ferfState}, 8'h01);
    readReg(8'h14, rd); chk("R8 entry event", rd, 8'h08);
    goodFrame(8'h00, 8'h18); goodFrame(8'h00, 8'h18);
    goodFrame(8'h00, 8'h98);
    goodFrame(8'h00, 8'h18); goodFrame(8'h00, 8'h18);
    chk("R7 run restarted", {7'd0, ferfState}, 8'h01);
    readReg(8'h14, rd); chk("R8 no spurious", rd, 8'h00);
    goodFrame(8'h00, 8'h18);
    chk("R7 n3 cleared", {7'd0, ferfState}, 8'h00);
    readReg(8'h14, rd); chk("R8 exit event", rd, 8'h08);

    // R7 N=5
    writeReg(8'h16, 8'h01);
    readReg(8'h16, rd); chk("R7 config readback", rd, 8'h01);
    for (int i = 0; i < 4; i++) goodFrame(8'h00, 8'h98);
    chk("R7 n5 not yet", {7'd0, ferfState}, 8'h00);
    goodFrame(8'h00, 8'h98);
    chk("R7 n5 declared", {7'd0, ferfState}, 8'h01);
    readReg(8'h14, rd); chk("R8 n5 event", rd, 8'h08);

    // R10 interrupt masking
    writeReg(8'h15, 8'h20);
    goodFrame(8'h80, 8'h98);
    chk("R10 irq enabled bit", {7'd0, irqOut}, 8'h01);
    readReg(8'h14, rd); chk("R9 read value", rd, 8'h20);
    chk("R10 irq after clear", {7'd0, irqOut}, 8'h00);
    goodFrame(8'h00, 8'hD8);
    chk("R10 masked irq", {7'd0, irqOut}, 8'h00);
    readReg(8'h14, rd); chk("R10 masked status", rd, 8'h10);

    // R9 event and read in the same cycle
    goodFrame(8'h00, 8'hD8);
    regRdEn = 1'b1; regAddr = 8'h14;
    fa1In = 8'hF6; fa2In = 8'h28; emIn = 8'h5C; bipIn = 8'h5C;
    trIn = 8'h80; maIn = 8'h98; frameStb = 1'b1;
    #1 rd = regRdData;
    chk("R9 same-cycle read old", rd, 8'h10);
    @(negedge clk);
    regRdEn = 1'b0; frameStb = 1'b0;
    chk("R9 event survives irq", {7'd0, irqOut}, 8'h01);
    readReg(8'h14, rd); chk("R9 event wins", rd, 8'h20);

    // R11 data-link routing
    writeReg(8'h18, 8'hFF);
    readReg(8'h18, rd); chk("R11 ctrl readback", rd, 8'h0E);
    writeReg(8'h18, 8'h0C);
    nrIn = 8'hA5; gcIn = 8'h5A; maIn = 8'h98; trIn = 8'h00; frameStb = 1'b1;
    #1 chk("R11 nr selected", dlByte, 8'hA5);
    chk("R11 valid", {7'd0, dlValid}, 8'h01);
    @(negedge clk); frameStb = 1'b0;
    #1 chk("R11 valid follows strobe", {7'd0, dlValid}, 8'h00);
    @(negedge clk);
    writeReg(8'h18, 8'h08);
    frameStb = 1'b1;
    #1 chk("R11 disabled", {7'd0, dlValid}, 8'h00);
    @(negedge clk); frameStb = 1'b0;
    writeReg(8'h18, 8'h04);
    frameStb = 1'b1;
    #1 chk("R11 gc selected", dlByte, 8'h5A);
    chk("R11 gc valid", {7'd0, dlValid}, 8'h01);
    @(negedge clk); frameStb = 1'b0;

    // R1 R6 mid-run reset and first-frame rule
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readReg(8'h18, rd); chk("R1 ctrl after reset", rd, 8'h00);
    readReg(8'h16, rd); chk("R1 config after reset", rd, 8'h00);
    chk("R1 ferf after reset", {6'd0, irqOut, ferfState}, 8'h00);
    goodFrame(8'h00, 8'h28);
    readReg(8'h14, rd); chk("R6 first frame not compared", rd, 8'h00);
    goodFrame(8'h00, 8'h28);
    readReg(8'h14, rd); chk("R6 same type", rd, 8'h00);
    goodFrame(8'h00, 8'h30);
    readReg(8'h14, rd); chk("R6 type change", rd, 8'h01);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule